// File: doc/BRIEF.md
# Flag-Handshake Dual-Port Mailbox

The mailbox sits between two neighbouring stages of a processor pipeline. A producer port and a consumer port share one word-addressed memory, 1K words of 16 bits by default. One word of that memory, the flag word, carries the hand-off state, and the rest of the memory holds the data slots. Any value can be written to the flag word, but it reads back as 0x0001 (set) or 0x0000 (clear).

The producer reads the flag word and continues only once it is clear, which means its previous data has been consumed. It then writes the data slot and writes a nonzero value to the flag word. The consumer waits for the flag, reads the slot and writes zero to the flag word.

A configuration input routes the flag to the consumer in one of two ways:
- Interrupt mode: a one-cycle event pulse marks each rise of the flag.
- Poll mode: a status level follows the flag.

Each port access takes one cycle. If both ports write the same word in the same cycle, the producer's write is kept and a collision strobe is raised.

Top module: `mbox_dualport`

## Requirements
- R1: After reset the flag is clear, both read-data outputs are 0x0000, and `c_irq`, `c_poll` and `wr_collision` are low.
- R2: A word written by either port to any address other than the flag address can be read from either port. A read access (`en`=1, `we`=0) presents its data on that port's `rdata` in the cycle after the access. `rdata` holds its value in cycles without a read access on that port.
- R3: A read and a write to the same address in the same cycle return the word as it was before the write.
- R4: A write of 0x0000 to the flag address clears the flag, and a write of any nonzero value sets it. A read of the flag address returns 0x0001 when the flag is set and 0x0000 when it is clear, on either port.
- R5: When both ports write the same address in the same cycle, the producer's value is stored, and `wr_collision` is high for exactly the following cycle. This holds for the flag address as well. Writes to different addresses in the same cycle both take effect and raise no collision.
- R6: With `evt_irq_sel`=1 (interrupt mode), `c_irq` is high for exactly one cycle, the cycle after a write that takes the flag from clear to set. A write that leaves the flag set gives no pulse. `c_poll` stays low in this mode.
- R7: With `evt_irq_sel`=0 (poll mode), `c_poll` equals the flag level, changing in the cycle after the write that changes the flag, and `c_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p_en | input | 1 | Producer port access enable |
| p_we | input | 1 | Producer write (1) or read (0) |
| p_addr | input | ADDR_W | Producer word address |
| p_wdata | input | 16 | Producer write data |
| p_rdata | output | 16 | Producer read data, one cycle after the access |
| c_en | input | 1 | Consumer port access enable |
| c_we | input | 1 | Consumer write (1) or read (0) |
| c_addr | input | ADDR_W | Consumer word address |
| c_wdata | input | 16 | Consumer write data |
| c_rdata | output | 16 | Consumer read data, one cycle after the access |
| evt_irq_sel | input | 1 | Event route: 1 selects the interrupt pulse, 0 selects the poll level |
| c_irq | output | 1 | One-cycle event pulse on each rise of the flag |
| c_poll | output | 1 | Flag status level for polling |
| wr_collision | output | 1 | Same-address double write seen in the previous cycle |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- Flag decode: values such as 0x8000 and 0x0002 must count as set. A design that tested only bit 0 would read such a flag back as clear and stall the handshake.
- Rewriting a set flag: this must not pulse the interrupt. A level-triggered event path would fire a second time for data already delivered.
- Same-cycle double writes to data and to the flag: the producer must win. With the wrong priority the consumer could erase fresh data or a fresh flag.
- Read during write: a read-during-write that returned the new word would break read-first behaviour.
- Data path sweep: the bench writes and reads back every data address of a small configuration through both ports, which exposes address or port crossings.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    parameter int unsigned MBOX_DATA_W = 16;

    typedef logic [MBOX_DATA_W-1:0] word_t;

    typedef enum logic {
        EVT_POLL = 1'b0,
        EVT_IRQ  = 1'b1
    } evt_mode_e;

    // Port index: producer has write priority.
    localparam int unsigned PORT_P = 0;
    localparam int unsigned PORT_C = 1;
    localparam int unsigned NUM_PORTS = 2;

    // Any nonzero word counts as a set flag.
    function automatic logic flag_decode(input word_t w);
        return |w;
    endfunction

    function automatic word_t flag_encode(input logic f);
        return {{(MBOX_DATA_W-1){1'b0}}, f};
    endfunction
endpackage

// File: rtl/mbox_wr_arb.sv
module mbox_wr_arb
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned FLAG_ADDR = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en      [NUM_PORTS],
    input  logic              we      [NUM_PORTS],
    input  logic [ADDR_W-1:0] addr    [NUM_PORTS],
    output logic              mem_wr  [NUM_PORTS],
    output logic              flag_wr [NUM_PORTS],
    output logic              rd      [NUM_PORTS],
    output logic              collision
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    logic wr_req [NUM_PORTS];
    logic clash;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
        assign wr_req[p] = en[p] & we[p];
        assign rd[p]     = en[p] & ~we[p];
    end

    assign clash = wr_req[PORT_P] & wr_req[PORT_C] & (addr[PORT_P] == addr[PORT_C]);

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            mem_wr[p]  = wr_req[p] & (addr[p] != FLAG_A);
            flag_wr[p] = wr_req[p] & (addr[p] == FLAG_A);
        end
        // Producer wins a same-address double write.
        if (clash) begin
            mem_wr[PORT_C]  = 1'b0;
            flag_wr[PORT_C] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) collision <= 1'b0;
        else     collision <= clash;
    end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flag_wr [NUM_PORTS],
    input  word_t wdata   [NUM_PORTS],
    output logic  flag_d,
    output logic  flag_q
);
    always_comb begin
        flag_d = flag_q;
        if (flag_wr[PORT_C]) flag_d = flag_decode(wdata[PORT_C]);
        if (flag_wr[PORT_P]) flag_d = flag_decode(wdata[PORT_P]);
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end
endmodule

// File: rtl/mbox_event.sv
module mbox_event
    import mbox_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  evt_mode_e mode,
    input  logic      flag_d,
    input  logic      flag_q,
    output logic      irq,
    output logic      poll
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= (mode == EVT_IRQ) & flag_d & ~flag_q;
    end

    assign poll = (mode == EVT_POLL) & flag_q;
endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned FLAG_ADDR = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wr [NUM_PORTS],
    input  logic              rd     [NUM_PORTS],
    input  logic [ADDR_W-1:0] addr   [NUM_PORTS],
    input  word_t             wdata  [NUM_PORTS],
    input  logic              flag_q,
    output word_t             rdata  [NUM_PORTS]
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    word_t mem [DEPTH];

    // Producer write is applied last so it wins.
    always_ff @(posedge clk) begin
        if (mem_wr[PORT_C]) mem[addr[PORT_C]] <= wdata[PORT_C];
        if (mem_wr[PORT_P]) mem[addr[PORT_P]] <= wdata[PORT_P];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[p] <= '0;
            end else if (rd[p]) begin
                if (addr[p] == FLAG_A) rdata[p] <= flag_encode(flag_q);
                else                   rdata[p] <= mem[addr[p]];
            end
        end
    end
endmodule

// File: rtl/mbox_dualport.sv
module mbox_dualport
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned FLAG_ADDR = 1023
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p_en,
    input  logic              p_we,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [15:0]       p_wdata,
    output logic [15:0]       p_rdata,
    input  logic              c_en,
    input  logic              c_we,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [15:0]       c_wdata,
    output logic [15:0]       c_rdata,
    input  logic              evt_irq_sel,
    output logic              c_irq,
    output logic              c_poll,
    output logic              wr_collision
);
    logic              en_a      [NUM_PORTS];
    logic              we_a      [NUM_PORTS];
    logic [ADDR_W-1:0] addr_a    [NUM_PORTS];
    word_t             wdata_a   [NUM_PORTS];
    word_t             rdata_a   [NUM_PORTS];
    logic              mem_wr_a  [NUM_PORTS];
    logic              flag_wr_a [NUM_PORTS];
    logic              rd_a      [NUM_PORTS];
    logic              flag_d, flag_q;
    evt_mode_e         mode;

    assign en_a[PORT_P]    = p_en;
    assign we_a[PORT_P]    = p_we;
    assign addr_a[PORT_P]  = p_addr;
    assign wdata_a[PORT_P] = p_wdata;
    assign en_a[PORT_C]    = c_en;
    assign we_a[PORT_C]    = c_we;
    assign addr_a[PORT_C]  = c_addr;
    assign wdata_a[PORT_C] = c_wdata;
    assign p_rdata = rdata_a[PORT_P];
    assign c_rdata = rdata_a[PORT_C];
    assign mode    = evt_irq_sel ? EVT_IRQ : EVT_POLL;

    mbox_wr_arb #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_arb (
        .clk(clk), .rst(rst), .en(en_a), .we(we_a), .addr(addr_a),
        .mem_wr(mem_wr_a), .flag_wr(flag_wr_a), .rd(rd_a),
        .collision(wr_collision)
    );

    mbox_flag u_flag (
        .clk(clk), .rst(rst), .flag_wr(flag_wr_a), .wdata(wdata_a),
        .flag_d(flag_d), .flag_q(flag_q)
    );

    mbox_event u_evt (
        .clk(clk), .rst(rst), .mode(mode), .flag_d(flag_d), .flag_q(flag_q),
        .irq(c_irq), .poll(c_poll)
    );

    mbox_store #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_store (
        .clk(clk), .rst(rst), .mem_wr(mem_wr_a), .rd(rd_a), .addr(addr_a),
        .wdata(wdata_a), .flag_q(flag_q), .rdata(rdata_a)
    );
endmodule

// File: rtl/mbox_dualport_chk.sv
module mbox_dualport_chk #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned FLAG_ADDR = 1023
) (
    input logic              clk,
    input logic              rst,
    input logic              p_en,
    input logic              p_we,
    input logic [ADDR_W-1:0] p_addr,
    input logic [15:0]       p_wdata,
    input logic [15:0]       p_rdata,
    input logic              c_en,
    input logic              c_we,
    input logic [ADDR_W-1:0] c_addr,
    input logic [15:0]       c_wdata,
    input logic [15:0]       c_rdata,
    input logic              evt_irq_sel,
    input logic              c_irq,
    input logic              c_poll,
    input logic              wr_collision
);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);

    logic same_wr;
    assign same_wr = p_en && p_we && c_en && c_we && (p_addr == c_addr);

    AST_COLLISION_SET: assert property (@(posedge clk) disable iff (rst)
        same_wr |=> wr_collision); // R5
    AST_COLLISION_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wr_collision |-> $past(same_wr)); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        c_irq |=> !c_irq); // R6
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        c_irq |-> $past(evt_irq_sel)); // R6
    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (rst)
        evt_irq_sel |-> !c_poll); // R7
    AST_FLAG_READ_FORM: assert property (@(posedge clk) disable iff (rst)
        $past(c_en && !c_we && c_addr == FLAG_A) |-> (c_rdata[15:1] == 15'd0)); // R4
endmodule

bind mbox_dualport mbox_dualport_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (.*);

// File: tb/mbox_dualport_test.sv
module mbox_dualport_test;
    localparam int unsigned AW = 4;
    localparam int unsigned FA = 15;
    localparam logic [AW-1:0] FLAG = AW'(FA);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          p_en = 0, p_we = 0, c_en = 0, c_we = 0;
    logic [AW-1:0] p_addr = '0, c_addr = '0;
    logic [15:0]   p_wdata = '0, c_wdata = '0;
    logic [15:0]   p_rdata, c_rdata;
    logic          evt_irq_sel = 1'b0;
    logic          c_irq, c_poll, wr_collision;

    int checks = 0;
    int errors = 0;

    mbox_dualport #(.ADDR_W(AW), .FLAG_ADDR(FA)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        p_en = 0; p_we = 0; c_en = 0; c_we = 0;
    endtask

    task automatic pw(input logic [AW-1:0] a, input logic [15:0] d);
        p_en = 1; p_we = 1; p_addr = a; p_wdata = d;
    endtask
    task automatic pr(input logic [AW-1:0] a);
        p_en = 1; p_we = 0; p_addr = a;
    endtask
    task automatic cw(input logic [AW-1:0] a, input logic [15:0] d);
        c_en = 1; c_we = 1; c_addr = a; c_wdata = d;
    endtask
    task automatic cr(input logic [AW-1:0] a);
        c_en = 1; c_we = 0; c_addr = a;
    endtask

    function automatic logic [15:0] pat(input int i, input logic [15:0] salt);
        return 16'(salt ^ 16'(i * 16'h0123));
    endfunction

    initial begin
        #5000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 p_rdata", p_rdata, 16'h0);
        chk("R1 c_rdata", c_rdata, 16'h0);
        chk("R1 irq/poll/coll", {13'd0, c_irq, c_poll, wr_collision}, 16'h0);
        cr(FLAG); step(); idle();
        chk("R1 flag clear", c_rdata, 16'h0);

        // R2 sweep: producer writes, consumer reads
        for (int i = 0; i < 15; i++) begin pw(AW'(i), pat(i, 16'hA55A)); step(); end
        idle();
        for (int i = 0; i < 15; i++) begin
            cr(AW'(i)); step();
            chk("R2 p->c", c_rdata, pat(i, 16'hA55A));
        end
        idle(); step();
        chk("R2 hold", c_rdata, pat(14, 16'hA55A));
        // R2 sweep: consumer writes, producer reads
        for (int i = 0; i < 15; i++) begin cw(AW'(i), pat(i, 16'h3C96)); step(); end
        idle();
        for (int i = 0; i < 15; i++) begin
            pr(AW'(i)); step();
            chk("R2 c->p", p_rdata, pat(i, 16'h3C96));
        end
        idle();

        // R3 read during write
        pw(4'd3, 16'hBEEF); cr(4'd3); step(); idle();
        chk("R3 old value", c_rdata, pat(3, 16'h3C96));
        cr(4'd3); step(); idle();
        chk("R3 new value", c_rdata, 16'hBEEF);

        // R4 flag decode over values, R7 poll level
        evt_irq_sel = 0;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'h0001 : (k == 1) ? 16'h8000 : (k == 2) ? 16'h0002 : 16'hFFFF;
            pw(FLAG, v); step(); idle();
            chk("R7 poll set", {15'd0, c_poll}, 16'h1);
            chk("R7 irq quiet", {15'd0, c_irq}, 16'h0);
            cr(FLAG); step(); idle();
            chk("R4 flag set read", c_rdata, 16'h0001);
            cw(FLAG, 16'h0000); step(); idle();
            chk("R7 poll clear", {15'd0, c_poll}, 16'h0);
            pr(FLAG); step(); idle();
            chk("R4 flag clear read", p_rdata, 16'h0000);
        end

        // R6 interrupt mode
        evt_irq_sel = 1;
        step();
        pw(FLAG, 16'h0040); step(); idle();
        chk("R6 pulse", {15'd0, c_irq}, 16'h1);
        chk("R6 poll low", {15'd0, c_poll}, 16'h0);
        step();
        chk("R6 pulse ends", {15'd0, c_irq}, 16'h0);
        pw(FLAG, 16'h0005); step(); idle();
        chk("R6 no pulse on rewrite", {15'd0, c_irq}, 16'h0);
        cw(FLAG, 16'h0); step(); idle();
        chk("R6 no pulse on clear", {15'd0, c_irq}, 16'h0);
        cw(FLAG, 16'h0100); step(); idle();
        chk("R6 pulse from consumer set", {15'd0, c_irq}, 16'h1);

        // R5 collisions
        pw(4'd7, 16'h1111); cw(4'd7, 16'h2222); step(); idle();
        chk("R5 collision strobe", {15'd0, wr_collision}, 16'h1);
        cr(4'd7); step(); idle();
        chk("R5 producer wins", c_rdata, 16'h1111);
        chk("R5 strobe one cycle", {15'd0, wr_collision}, 16'h0);
        pw(FLAG, 16'h0); cw(FLAG, 16'h1); step(); idle();
        chk("R5 flag collision", {15'd0, wr_collision}, 16'h1);
        pr(FLAG); step(); idle();
        chk("R5 flag producer wins", p_rdata, 16'h0);
        pw(4'd1, 16'h5151); cw(4'd2, 16'h5252); step(); idle();
        chk("R5 no collision diff addr", {15'd0, wr_collision}, 16'h0);
        pr(4'd1); cr(4'd2); step(); idle();
        chk("R5 both written p", p_rdata, 16'h5151);
        chk("R5 both written c", c_rdata, 16'h5252);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule